// File: doc/BRIEF.md
# Dual-Order Four-Beat Burst Address Sequencer

This block produces the address of every beat in a four-beat burst. When an address strobe is accepted, it captures a base address. On each later clock where the active-low step input is low, it moves the two low address bits to the next position in the burst. The upper address bits keep the value captured at the load.

Two burst orders are available. Linear order counts upward and wraps within the aligned group of four. Interleaved order XORs the start offset with the beat count. A static strap chooses the order. The strap is taken into the block only while reset is held.

Two strobes can start a burst. The processor strobe has priority over the controller strobe. The processor strobe is accepted only while chip select 1 is active. Both strobes also need the select qualifier, which is driven from outside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: While synchronous reset is high at a clock edge, the next outputs are addr_out = 0 and beat_idx = 0.
- R2: When proc_stb, cs1_act and sel_ok are all high at a clock edge, the next cycle shows addr_out equal to the addr_in of that edge, all bits included, and beat_idx = 0.
- R3: When ctrl_stb and sel_ok are high at a clock edge, the address is loaded as in R2. If the processor strobe is also accepted at that edge, the processor strobe takes the load.
- R4: proc_stb has no effect while cs1_act is low. A ctrl_stb asserted at the same edge still loads.
- R5: Neither strobe loads while sel_ok is low.
- R6: When no load occurs and step_n is low at an edge, beat_idx increases by one modulo 4. After four steps the burst returns to its start address.
- R7: When no load occurs and step_n is high, addr_out and beat_idx hold their values. This suspends the burst.
- R8: On an edge where a strobe is accepted, step_n is ignored and beat_idx becomes 0.
- R9: With the strap latched low (linear order), addr_out[1:0] = (start + beat_idx) mod 4. Starting at 01, the burst runs 01, 10, 11, 00.
- R10: With the strap latched high (interleaved order), addr_out[1:0] = start XOR beat_idx. Starting at 10, the burst runs 10, 11, 00, 01.
- R11: addr_out[ADDR_W-1:2] does not change between loads.
- R12: A change of mode_strap while reset is low has no effect on the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; also latches the order strap |
| mode_strap | input | 1 | Order strap: 0 selects linear, 1 selects interleaved |
| cs1_act | input | 1 | Chip select 1 is active (high); gates the processor strobe |
| sel_ok | input | 1 | Select qualifier; high when the device is selected |
| proc_stb | input | 1 | Processor address strobe, active high |
| ctrl_stb | input | 1 | Controller address strobe, active high |
| step_n | input | 1 | Burst advance, active low |
| addr_in | input | ADDR_W | Base address captured on an accepted strobe |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Number of beats stepped since the last load |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. The state registers drive the outputs through logic only, with no further register stage. The bench therefore changes inputs on the falling edge and samples one nanosecond after each rising edge. At that point it compares both outputs with a behavioural model updated from the inputs of that same edge. Fixed burst sequences for both orders are also checked against hard-coded values. A reset with the other strap value is needed before the interleaved order can be observed.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   localparam int OFS_W = 2;
   typedef logic [OFS_W-1:0] ofs_t;
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } order_e;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
   input  logic proc_stb,
   input  logic ctrl_stb,
   input  logic cs1_act,
   input  logic sel_ok,
   output logic load_en,
   output logic load_by_proc
);
   logic proc_take;
   logic ctrl_take;

   // The processor strobe wins; the controller strobe only counts when the processor strobe is not taken.
   assign proc_take    = proc_stb & cs1_act & sel_ok;
   assign ctrl_take    = ctrl_stb & sel_ok & ~proc_take;
   assign load_en      = proc_take | ctrl_take;
   assign load_by_proc = proc_take;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_seq_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic adv,
   output ofs_t beat
);
   always_ff @(posedge clk) begin
      if (rst || load) beat <= '0;
      else if (adv)    beat <= beat + ofs_t'(1);
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
(
   input  order_e order,
   input  ofs_t   start,
   input  ofs_t   beat,
   output ofs_t   ofs
);
   ofs_t lin_ofs;
   ofs_t xor_ofs;

   assign lin_ofs = start + beat;

   for (genvar b = 0; b < OFS_W; b++) begin : g_xor
      assign xor_ofs[b] = start[b] ^ beat[b];
   end

   assign ofs = (order == ORD_XOR) ? xor_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_strap,
   input  logic              cs1_act,
   input  logic              sel_ok,
   input  logic              proc_stb,
   input  logic              ctrl_stb,
   input  logic              step_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [1:0]        beat_idx
);
   localparam int UP_W = ADDR_W - OFS_W;

   if (ADDR_W <= OFS_W) begin : g_bad_width
      $error("burst_addr_seq: ADDR_W must exceed the burst offset width");
   end

   logic            load_en;
   logic            load_by_proc;
   order_e          mode_q;
   logic [UP_W-1:0] upper_q;
   ofs_t            start_q;
   ofs_t            beat_q;
   ofs_t            cur_ofs;

   burst_load_ctl u_load (
      .proc_stb     (proc_stb),
      .ctrl_stb     (ctrl_stb),
      .cs1_act      (cs1_act),
      .sel_ok       (sel_ok),
      .load_en      (load_en),
      .load_by_proc (load_by_proc)
   );

   // The order strap is static, so it is taken in only while reset is held.
   always_ff @(posedge clk) begin
      if (rst) mode_q <= order_e'(mode_strap);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         upper_q <= '0;
         start_q <= '0;
      end else if (load_en) begin
         upper_q <= addr_in[ADDR_W-1:OFS_W];
         start_q <= addr_in[OFS_W-1:0];
      end
   end

   burst_beat_ctr u_beat (
      .clk  (clk),
      .rst  (rst),
      .load (load_en),
      .adv  (~step_n),
      .beat (beat_q)
   );

   burst_order_map u_map (
      .order (mode_q),
      .start (start_q),
      .beat  (beat_q),
      .ofs   (cur_ofs)
   );

   assign addr_out = {upper_q, cur_ofs};
   assign beat_idx = beat_q;

   // Which strobe took the load is not visible at the ports.
   logic unused_src;
   assign unused_src = load_by_proc;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst,
   input logic              cs1_act,
   input logic              sel_ok,
   input logic              proc_stb,
   input logic              ctrl_stb,
   input logic              step_n,
   input logic              mode_q,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out,
   input logic [1:0]        beat_idx
);
   logic took;
   assign took = (proc_stb && cs1_act && sel_ok) || (ctrl_stb && sel_ok);

   a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
      took |=> (addr_out == $past(addr_in)) && (beat_idx == 2'd0));

   a_r5_no_load_unselected: assert property (@(posedge clk) disable iff (rst)
      (!sel_ok && step_n) |=> $stable(addr_out) && $stable(beat_idx));

   a_r6_step_counts: assert property (@(posedge clk) disable iff (rst)
      (!took && !step_n) |=> beat_idx == $past(beat_idx) + 2'd1);

   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (!took && step_n) |=> $stable(addr_out) && $stable(beat_idx));

   a_r9_linear_start_kept: assert property (@(posedge clk) disable iff (rst)
      (!took && !mode_q) |=> (2'(addr_out[1:0] - beat_idx)) == $past(2'(addr_out[1:0] - beat_idx)));

   a_r10_xor_start_kept: assert property (@(posedge clk) disable iff (rst)
      (!took && mode_q) |=> (addr_out[1:0] ^ beat_idx) == $past(addr_out[1:0] ^ beat_idx));

   a_r11_upper_held: assert property (@(posedge clk) disable iff (rst)
      !took |=> $stable(addr_out[ADDR_W-1:2]));

   a_r12_mode_static: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(mode_q));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .cs1_act  (cs1_act),
   .sel_ok   (sel_ok),
   .proc_stb (proc_stb),
   .ctrl_stb (ctrl_stb),
   .step_n   (step_n),
   .mode_q   (mode_q),
   .addr_in  (addr_in),
   .addr_out (addr_out),
   .beat_idx (beat_idx)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
   localparam int ADDR_W = 17;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode_strap = 1'b0;
   logic cs1_act = 1'b1;
   logic sel_ok = 1'b1;
   logic proc_stb = 1'b0;
   logic ctrl_stb = 1'b0;
   logic step_n = 1'b1;
   logic [ADDR_W-1:0] addr_in = '0;
   logic [ADDR_W-1:0] addr_out;
   logic [1:0]        beat_idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_addr = 0;
   int m_beat = 0;
   int m_mode = 0;

   always #2 clk = ~clk;

   burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst(rst), .mode_strap(mode_strap), .cs1_act(cs1_act),
      .sel_ok(sel_ok), .proc_stb(proc_stb), .ctrl_stb(ctrl_stb),
      .step_n(step_n), .addr_in(addr_in), .addr_out(addr_out), .beat_idx(beat_idx)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_addr();
      int lo;
      lo = (m_mode != 0) ? ((m_addr & 3) ^ m_beat) : (((m_addr & 3) + m_beat) % 4);
      return (m_addr & ~3) | lo;
   endfunction

   // One clock: update the model on the rising edge, compare just after it, then return at the falling edge.
   task automatic tick(string tag);
      @(posedge clk);
      if (rst) begin
         m_addr = 0; m_beat = 0; m_mode = int'(mode_strap);
      end else if ((proc_stb && cs1_act && sel_ok) || (ctrl_stb && sel_ok)) begin
         m_addr = int'(addr_in); m_beat = 0;
      end else if (!step_n) begin
         m_beat = (m_beat + 1) % 4;
      end
      #1;
      chk({tag, " addr"}, int'(addr_out), exp_addr());
      chk({tag, " beat"}, int'(beat_idx), m_beat);
      @(negedge clk);
   endtask

   task automatic idle();
      proc_stb = 0; ctrl_stb = 0; step_n = 1; cs1_act = 1; sel_ok = 1;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick("R1 reset");
      step_n = 0; tick("R1 reset ignores step");
      chk("R1 addr zero", int'(addr_out), 0);
      rst = 0; idle(); tick("R7 idle hold");

      // R2 processor load, linear order from 01 (R9).
      addr_in = 17'h1ABC5; proc_stb = 1; step_n = 0; tick("R2 R8 proc load");
      chk("R2 addr", int'(addr_out), 'h1ABC5);
      idle(); step_n = 0;
      tick("R9 step1"); chk("R9 second beat", int'(addr_out) & 3, 2);
      tick("R9 step2"); chk("R9 third beat", int'(addr_out) & 3, 3);
      tick("R9 step3"); chk("R9 fourth beat", int'(addr_out) & 3, 0);
      chk("R11 upper kept", int'(addr_out) >> 2, 'h1ABC5 >> 2);
      tick("R6 wrap"); chk("R6 back to start", int'(addr_out), 'h1ABC5);
      step_n = 1; tick("R7 suspend"); tick("R7 suspend2");

      // R4: processor strobe ignored while chip select 1 inactive.
      cs1_act = 0; proc_stb = 1; addr_in = 17'h00F0A; tick("R4 proc ignored");
      chk("R4 no load", int'(addr_out), 'h1ABC5);
      ctrl_stb = 1; tick("R4 ctrl loads");
      chk("R4 ctrl addr", int'(addr_out), 'h00F0A);

      // R5: nothing loads while unselected.
      idle(); sel_ok = 0; ctrl_stb = 1; proc_stb = 1; addr_in = 17'h12345; tick("R5 unselected");
      chk("R5 no load", int'(addr_out), 'h00F0A);

      // R3: controller load with a step request that must be ignored (R8).
      idle(); ctrl_stb = 1; step_n = 0; addr_in = 17'h0F00F; tick("R3 R8 ctrl load");
      chk("R8 beat zero", int'(beat_idx), 0);
      idle(); proc_stb = 1; ctrl_stb = 1; addr_in = 17'h05553; tick("R3 both strobes");

      // R12: changing the strap without reset keeps linear order.
      idle(); mode_strap = 1; step_n = 0;
      tick("R12 step1"); chk("R12 linear kept", int'(addr_out) & 3, 0);
      tick("R12 step2");

      // R10: reset with strap high, interleaved from 10.
      rst = 1; idle(); tick("R1 reset again");
      rst = 0; addr_in = 17'h0ACE6; proc_stb = 1; tick("R10 load");
      chk("R10 first", int'(addr_out) & 3, 2);
      idle(); step_n = 0;
      tick("R10 s1"); chk("R10 second", int'(addr_out) & 3, 3);
      tick("R10 s2"); chk("R10 third", int'(addr_out) & 3, 0);
      tick("R10 s3"); chk("R10 fourth", int'(addr_out) & 3, 1);
      tick("R6 xor wrap"); chk("R6 xor start", int'(addr_out), 'h0ACE6);
      mode_strap = 0;
      for (int i = 0; i < 20; i++) begin
         step_n = (i % 3 == 0);
         proc_stb = (i % 7 == 5);
         ctrl_stb = (i % 5 == 2);
         cs1_act = (i % 2 == 0);
         addr_in = ADDR_W'(i * 4099 + 1);
         tick("R6 R7 R12 mixed");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule